// File: doc/BRIEF.md
# Limit Counter Timer Bank with Acknowledge-on-Read

This block holds one system timer and a set of per-processor profiling timers. Each timer shares one external microsecond tick enable. Each timer advances its count on every tick. When the incremented count would equal the programmed limit, the count reloads to 1 and the timer raises a level interrupt. That interrupt stays high until software reads the timer's limit register. A second read-only view of the limit returns the same value without acknowledging the interrupt. This lets a monitor inspect the setting without disturbing the handler.

Software writes the limit as `(period_us + 1) << 10`, so the interrupt fires every `period_us` ticks. A limit of zero leaves the timer counting with no periodic interrupt. The global timer feeds the system-timer interrupt line. Each per-processor timer feeds its own processor's profiling line.

Top module: `tmr_bank`

## Requirements
- R1: The word address is `{bank, sel}`, with `sel` in the two low bits. Banks 0 to NUM_CPU-1 are the per-processor timers and bank NUM_CPU is the global timer. `sel` 0 is the limit register, 1 is the count, 2 is the limit view that does not acknowledge, and 3 reads zero. Any other bank reads zero and ignores writes. `rdata` is registered: it carries the addressed value in the cycle after `rd_en`, and it is zero after a cycle without a read.
- R2: A write to `sel` 0 stores `wdata[30:10]` as the limit. In the same edge it sets the count to 1 and drops any pending interrupt. Reads of `sel` 0 or 2 return the limit in bits 30:10, with all other bits zero.
- R3: On every cycle with `tick` high, the count increments. If the incremented value equals a non-zero limit, the count instead becomes 1 and the interrupt sets. With limit L, the interrupt therefore rises every L-1 ticks.
- R4: A set interrupt stays high through further ticks. A read of `sel` 0 clears it, and the line is low one cycle after the read.
- R5: A read of `sel` 2 leaves the interrupt unchanged.
- R6: With a limit of zero, the count keeps incrementing on ticks, wrapping modulo 2^21, and the interrupt never sets.
- R7: A read of `sel` 1 returns the count in bits 30:10, with bits 31 and 9:0 zero.
- R8: If a wrap and an acknowledging read fall in the same cycle, the interrupt stays set.
- R9: Writes to `sel` 1 and `sel` 3 change no limit, count or interrupt.
- R10: `irq_prof[i]` is the interrupt of bank i, and `irq_sys` is the interrupt of bank NUM_CPU. An event in one timer leaves every other line low.
- R11: After a synchronous reset, every limit is 0, every count is 1, every interrupt is low, and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Microsecond count enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | clog2(NUM_CPU+1)+2 | Word address {bank, sel} |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| irq_prof | output | NUM_CPU | Per-processor profiling interrupts |
| irq_sys | output | 1 | System timer interrupt |

## Verification
The bench drives a tick as a one-cycle pulse. Each result lands at the first rising edge after its stimulus:
- a count update and an interrupt set appear after that edge;
- an interrupt clear appears after the edge that samples the read;
- read data appears in the cycle after the read strobe.

The bench drives all stimulus on the falling edge and samples only on the next falling edge. Each expected count is therefore simply one plus the number of ticks given since the last reload. The sweep repeats this for every bank with a different period each time.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W    = 32;
    localparam int FIELD_LSB = 10;

    typedef enum logic [1:0] {
        SEL_LIMIT = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_PEEK  = 2'd2,
        SEL_NONE  = 2'd3
    } tmr_sel_e;

    typedef struct packed {
        logic load;
        logic ack;
    } tmr_ctl_t;

    function automatic logic [DATA_W-1:0] place_field(input logic [DATA_W-1:0] v);
        return v << FIELD_LSB;
    endfunction
endpackage

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  tmr_ctl_t         ctl,
    input  logic [CNT_W-1:0] new_limit,
    output logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    logic [CNT_W-1:0] count_inc;
    logic             wrap;

    always_comb begin
        count_inc = count + 1'b1;
        wrap      = tick && (limit != '0) && (count_inc == limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit <= '0;
            count <= CNT_W'(1);
            irq   <= 1'b0;
        end else if (ctl.load) begin
            limit <= new_limit;
            count <= CNT_W'(1);
            irq   <= 1'b0;
        end else begin
            if (wrap)         count <= CNT_W'(1);
            else if (tick)    count <= count_inc;
            if (wrap)         irq <= 1'b1;
            else if (ctl.ack) irq <= 1'b0;
        end
    end

    a_r4_irq_holds: assert property (@(posedge clk) disable iff (rst)
        (irq && !ctl.ack && !ctl.load) |=> irq);
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ctl.ack && !ctl.load && !tick) |=> !irq);
    a_r3_count_below_limit: assert property (@(posedge clk) disable iff (rst)
        (limit > CNT_W'(1)) |-> (count < limit));
    a_r6_zero_limit_quiet: assert property (@(posedge clk) disable iff (rst)
        (limit == '0 && !irq) |=> !irq);
    a_r2_load_resets: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (count == CNT_W'(1) && !irq));
endmodule

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int BANKS  = 5,
    parameter int BANK_W = 3
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BANK_W+1:0] addr,
    output logic              bank_ok,
    output logic [BANK_W-1:0] bank,
    output tmr_sel_e          sel,
    output tmr_ctl_t          ctl [BANKS]
);
    always_comb begin
        bank    = addr[BANK_W+1:2];
        sel     = tmr_sel_e'(addr[1:0]);
        bank_ok = (32'(bank) < BANKS);
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic hit;
        assign hit        = bank_ok && (32'(bank) == b) && (sel == SEL_LIMIT);
        assign ctl[b].load = hit && wr_en;
        assign ctl[b].ack  = hit && rd_en;
    end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CNT_W   = 21
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             tick,
    input  logic                             wr_en,
    input  logic                             rd_en,
    input  logic [$clog2(NUM_CPU+1)+1:0]     addr,
    input  logic [31:0]                      wdata,
    output logic [31:0]                      rdata,
    output logic [NUM_CPU-1:0]               irq_prof,
    output logic                             irq_sys
);
    localparam int BANKS  = NUM_CPU + 1;
    localparam int BANK_W = $clog2(BANKS);

    logic              bank_ok;
    logic [BANK_W-1:0] bank;
    tmr_sel_e          sel;
    tmr_ctl_t          ctl   [BANKS];
    logic [CNT_W-1:0]  lim_a [BANKS];
    logic [CNT_W-1:0]  cnt_a [BANKS];
    logic [BANKS-1:0]  irq_a;
    logic [CNT_W-1:0]  new_limit;
    logic [31:0]       rd_val;

    assign new_limit = wdata[FIELD_LSB +: CNT_W];

    tmr_decode #(.BANKS(BANKS), .BANK_W(BANK_W)) u_dec (
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .bank_ok(bank_ok), .bank(bank), .sel(sel), .ctl(ctl)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_tmr
        tmr_unit #(.CNT_W(CNT_W)) u_tmr (
            .clk(clk), .rst(rst), .tick(tick), .ctl(ctl[b]),
            .new_limit(new_limit), .limit(lim_a[b]), .count(cnt_a[b]),
            .irq(irq_a[b])
        );
    end

    assign irq_prof = irq_a[NUM_CPU-1:0];
    assign irq_sys  = irq_a[NUM_CPU];

    always_comb begin
        rd_val = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (bank_ok && 32'(bank) == b) begin
                case (sel)
                    SEL_LIMIT, SEL_PEEK: rd_val = place_field(32'(lim_a[b]));
                    SEL_COUNT:           rd_val = place_field(32'(cnt_a[b]));
                    default:             rd_val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_val;
        else            rdata <= '0;
    end

    a_r1_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rdata == '0));
    a_r10_sys_needs_tick: assert property (@(posedge clk) disable iff (rst)
        !irq_sys |=> (!irq_sys || $past(tick)));
    a_r2_field_only: assert property (@(posedge clk) disable iff (rst)
        (rdata[FIELD_LSB-1:0] == '0));
endmodule

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
    localparam int NUM_CPU = 4;
    localparam int AW      = $clog2(NUM_CPU+1) + 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NUM_CPU-1:0] irq_prof;
    logic              irq_sys;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    tmr_bank #(.NUM_CPU(NUM_CPU), .CNT_W(21)) dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_prof(irq_prof), .irq_sys(irq_sys)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    function automatic logic irq_of(input int b);
        return (b < NUM_CPU) ? irq_prof[b] : irq_sys;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input int b, input int s, input logic [31:0] d);
        @(negedge clk);
        addr = AW'((b << 2) | s); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input int b, input int s, input logic with_tick, output logic [31:0] d);
        @(negedge clk);
        addr = AW'((b << 2) | s); rd_en = 1'b1; tick = with_tick;
        @(negedge clk);
        rd_en = 1'b0; tick = 1'b0;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 irq lines", {27'd0, irq_sys, irq_prof}, 32'd0);
        check("R11 rdata", rdata, 32'd0);
        for (int b = 0; b <= NUM_CPU; b++) begin
            do_read(b, 0, 1'b0, d); check("R11 limit", d, 32'd0);
        end
        do_read(2, 1, 1'b0, d); check("R11 count", d, 32'd1 << 10);

        // main sweep over every bank with different periods
        for (int b = 0; b <= NUM_CPU; b++) begin
            int p = b + 3;
            do_write(b, 0, (p + 1) << 10);
            do_read(b, 1, 1'b0, d); check("R2 count reload", d, 32'd1 << 10);
            do_read(b, 2, 1'b0, d); check("R2 limit field", d, (p + 1) << 10);
            ticks(p - 1);
            check("R3 no early irq", {31'd0, irq_of(b)}, 32'd0);
            do_read(b, 1, 1'b0, d); check("R7 count value", d, p << 10);
            ticks(1);
            check("R3 irq at period", {31'd0, irq_of(b)}, 32'd1);
            check("R10 others quiet", {27'd0, irq_sys, irq_prof}, 32'd1 << b);
            do_read(b, 1, 1'b0, d); check("R3 reload to 1", d, 32'd1 << 10);
            do_read(b, 2, 1'b0, d); check("R5 peek value", d, (p + 1) << 10);
            check("R5 peek keeps irq", {31'd0, irq_of(b)}, 32'd1);
            ticks(2);
            check("R4 irq held", {31'd0, irq_of(b)}, 32'd1);
            do_read(b, 0, 1'b0, d); check("R4 ack read value", d, (p + 1) << 10);
            check("R4 ack clears", {31'd0, irq_of(b)}, 32'd0);
            ticks(p - 3);
            do_read(b, 0, 1'b1, d);
            check("R8 wrap beats ack", {31'd0, irq_of(b)}, 32'd1);
            do_write(b, 0, 32'd0);
            check("R2 write clears irq", {31'd0, irq_of(b)}, 32'd0);
        end

        // R6 zero limit
        do_write(1, 0, 32'd0);
        ticks(50);
        check("R6 no irq", {27'd0, irq_sys, irq_prof}, 32'd0);
        do_read(1, 1, 1'b0, d); check("R6 free count", d, 32'd51 << 10);

        // R9 ignored writes
        do_write(1, 1, 32'h0000_7C00);
        do_write(1, 3, 32'h0000_7C00);
        do_read(1, 1, 1'b0, d); check("R9 count untouched", d, 32'd51 << 10);
        do_read(1, 0, 1'b0, d); check("R9 limit untouched", d, 32'd0);

        // R1 map edges
        do_write(7, 0, 32'd3 << 10);
        for (int b = 0; b <= NUM_CPU; b++) begin
            do_read(b, 0, 1'b0, d); check("R1 bad bank write ignored", d, 32'd0);
        end
        do_read(7, 2, 1'b0, d); check("R1 bad bank reads 0", d, 32'd0);
        do_read(0, 3, 1'b0, d); check("R1 sel 3 reads 0", d, 32'd0);
        @(negedge clk);
        check("R1 idle rdata", rdata, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule